// File: doc/BRIEF.md
# Floating-Point Pipeline Issue Controller

This block sits between instruction dispatch and a floating-point execution pipeline that can hold several operations at once. It sees only the decoded operation class and a valid/ready handshake. It never touches operands. It decides when an operation may enter the pipeline, and holds each accepted operation for the latency of its class. When an operation finishes, it raises a one-cycle completion pulse. The pulse carries the tag that was handed out at dispatch, and a flag telling branch logic whether the condition result may be used at once.

Two kinds of operation share the unit. Ordinary classes are pipelined: each has a short fixed latency and an issue interval. Long and control-type classes take over the whole unit. They enter only when the pipeline is empty, and nothing follows them until they finish. For divide and reciprocal estimate, the latency comes from an input at dispatch and is clamped into a legal range. A synchronous flush drops all in-flight work.

Top module: `fp_issue_ctrl`

## Requirements
- R1: At most three operations are in flight at once. While three are outstanding, `dsp_ready_o` is low.
- R2: Class codes 0 (fast), 5 (status/control move), 6 (status field to condition) and 7 (reserved, treated as fast) have latency 3. Classes 1 (slow) and 2 (medium) have latency 4. Latency L means that `cmp_valid_o` is high in the cycle that begins L rising edges after the accepting edge, unless R7 delays it.
- R3: Class 1 has an issue interval of two cycles, so `dsp_ready_o` is low in the cycle after it is accepted. Every other ordinary class has an interval of one cycle and allows back-to-back acceptance.
- R4: Classes 3 (divide) and 4 (reciprocal estimate) take their latency from `dsp_lat_i`. A value below 18 becomes 18, a value above 33 becomes 33, and values in between are used as given.
- R5: Classes 3, 4 and 5 are blocking. One of them is accepted only when nothing is in flight, and while it is in flight no operation is accepted.
- R6: `cmp_valid_o` is a single-cycle pulse per completed operation. `cmp_fwd_o` is high with it for every class except class 6, and is never high without it.
- R7: Completions leave in dispatch order and carry the 2-bit tag shown on `dsp_tag_o` when the operation was accepted. Tags count up by one per acceptance and wrap. An operation completes at the later of its own latency and one cycle after the previous completion.
- R8: A cycle with `flush_i` high drops all in-flight operations and the issue interval. It also resets the tag counter to 0. In the next cycle `dsp_ready_o` is high, and no completion is reported for the dropped operations.
- R9: After reset, `dsp_ready_o` is high, `cmp_valid_o` and `cmp_fwd_o` are low, and `dsp_tag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Drop all in-flight state |
| dsp_valid_i | input | 1 | Dispatch request |
| dsp_ready_o | output | 1 | Dispatch may be accepted this cycle |
| dsp_cls_i | input | 3 | Operation class code |
| dsp_lat_i | input | 6 | Requested latency for long classes |
| dsp_tag_o | output | 2 | Tag given to the next accepted operation |
| cmp_valid_o | output | 1 | Completion pulse |
| cmp_tag_o | output | 2 | Tag of the completing operation |
| cmp_fwd_o | output | 1 | Condition result may be forwarded at once |

## Verification
The bench builds the block with its default parameters: depth three, 6-bit latency field and 2-bit tags. With these values, a full pipeline and tag wrap-around appear within a few operations. The clamp bounds 18 and 33 sit inside the 0 to 63 input range, so values on both sides of each bound can be driven. The table covers every class code from an empty pipeline, including clamp edges. Directed runs cover back-to-back fill, in-order delay, blocking waits and a flush during a long divide.

// File: rtl/fpi_pkg.sv
`timescale 1ns/1ps
package fpi_pkg;

  typedef enum logic [2:0] {
    OPC_FAST  = 3'd0,
    OPC_SLOW  = 3'd1,
    OPC_MIDL  = 3'd2,
    OPC_DIV   = 3'd3,
    OPC_RECIP = 3'd4,
    OPC_CSRMV = 3'd5,
    OPC_ST2CR = 3'd6,
    OPC_RSVD  = 3'd7
  } opc_e;

  typedef struct packed {
    logic       blocking;
    logic       fwd;
    logic       long_op;
    logic [2:0] base_lat;
    logic [1:0] ivl;
  } op_attr_t;

  function automatic op_attr_t attr_of(opc_e c);
    op_attr_t a;
    a = '{blocking: 1'b0, fwd: 1'b1, long_op: 1'b0, base_lat: 3'd3, ivl: 2'd1};
    case (c)
      OPC_SLOW:  begin a.base_lat = 3'd4; a.ivl = 2'd2; end
      OPC_MIDL:  a.base_lat = 3'd4;
      OPC_DIV,
      OPC_RECIP: begin a.blocking = 1'b1; a.long_op = 1'b1; end
      OPC_CSRMV: a.blocking = 1'b1;
      OPC_ST2CR: a.fwd = 1'b0;
      default:   ;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/fpi_class_decode.sv
`timescale 1ns/1ps
module fpi_class_decode #(
  parameter int LAT_W    = 6,
  parameter int IVL_W    = 2,
  parameter int LONG_MIN = 18,
  parameter int LONG_MAX = 33
) (
  input  logic [2:0]       cls_i,
  input  logic [LAT_W-1:0] lat_req_i,
  output logic [LAT_W-1:0] lat_eff_o,
  output logic [IVL_W-1:0] ivl_o,
  output logic             blocking_o,
  output logic             fwd_o
);
  import fpi_pkg::*;

  op_attr_t         attr;
  logic [LAT_W-1:0] clamped;

  always_comb begin
    attr = attr_of(opc_e'(cls_i));
    if (lat_req_i < LAT_W'(LONG_MIN))      clamped = LAT_W'(LONG_MIN);
    else if (lat_req_i > LAT_W'(LONG_MAX)) clamped = LAT_W'(LONG_MAX);
    else                                   clamped = lat_req_i;
    lat_eff_o  = attr.long_op ? clamped : LAT_W'(attr.base_lat);
    ivl_o      = IVL_W'(attr.ivl);
    blocking_o = attr.blocking;
    fwd_o      = attr.fwd;
  end
endmodule

// File: rtl/fpi_inflight_queue.sv
`timescale 1ns/1ps
module fpi_inflight_queue #(
  parameter int DEPTH = 3,
  parameter int LAT_W = 6,
  parameter int TAG_W = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [LAT_W-1:0] push_cnt_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic             push_fwd_i,
  input  logic             push_blk_i,
  output logic             pop_o,
  output logic [TAG_W-1:0] head_tag_o,
  output logic             head_fwd_o,
  output logic             blk_busy_o,
  output logic [OCC_W-1:0] occ_o
);
  logic [LAT_W-1:0] cnt_q [DEPTH];
  logic [LAT_W-1:0] cnt_d [DEPTH];
  logic [LAT_W-1:0] cnt_x [DEPTH+1];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [TAG_W-1:0] tag_d [DEPTH];
  logic [TAG_W-1:0] tag_x [DEPTH+1];
  logic [DEPTH:0]   fwd_x, blk_x;
  logic [DEPTH-1:0] fwd_q, fwd_d, blk_q, blk_d;
  logic [OCC_W-1:0] occ_q, occ_d, wr_idx;

  assign pop_o      = (occ_q != '0) && (cnt_q[0] == '0);
  assign wr_idx     = occ_q - OCC_W'(pop_o);
  assign head_tag_o = tag_q[0];
  assign head_fwd_o = fwd_q[0];
  assign blk_busy_o = (occ_q != '0) && blk_q[0];
  assign occ_o      = occ_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cnt_x[i] = cnt_q[i];
      tag_x[i] = tag_q[i];
      fwd_x[i] = fwd_q[i];
      blk_x[i] = blk_q[i];
    end
    cnt_x[DEPTH] = '0;
    tag_x[DEPTH] = '0;
    fwd_x[DEPTH] = 1'b0;
    blk_x[DEPTH] = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [LAT_W-1:0] sc;
      sc       = pop_o ? cnt_x[i+1] : cnt_x[i];
      tag_d[i] = pop_o ? tag_x[i+1] : tag_x[i];
      fwd_d[i] = pop_o ? fwd_x[i+1] : fwd_x[i];
      blk_d[i] = pop_o ? blk_x[i+1] : blk_x[i];
      cnt_d[i] = (sc != '0) ? sc - 1'b1 : '0;
      if (push_i && wr_idx == OCC_W'(i)) begin
        cnt_d[i] = push_cnt_i;
        tag_d[i] = push_tag_i;
        fwd_d[i] = push_fwd_i;
        blk_d[i] = push_blk_i;
      end
    end
    occ_d = occ_q + OCC_W'(push_i) - OCC_W'(pop_o);
  end

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      occ_q <= '0;
      fwd_q <= '0;
      blk_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cnt_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else begin
      occ_q <= occ_d;
      fwd_q <= fwd_d;
      blk_q <= blk_d;
      for (int i = 0; i < DEPTH; i++) begin
        cnt_q[i] <= cnt_d[i];
        tag_q[i] <= tag_d[i];
      end
    end
  end
endmodule

// File: rtl/fpi_issue_gate.sv
`timescale 1ns/1ps
module fpi_issue_gate #(
  parameter int DEPTH = 3,
  parameter int TAG_W = 2,
  parameter int IVL_W = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             valid_i,
  input  logic             blocking_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic             blk_busy_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [IVL_W-1:0] gap_q;
  logic [TAG_W-1:0] tag_q;

  assign ready_o  = (gap_q == '0) && !blk_busy_i && (occ_i < OCC_W'(DEPTH))
                  && (!blocking_i || occ_i == '0);
  assign accept_o = valid_i && ready_o && !flush_i;
  assign tag_o    = tag_q;

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      gap_q <= '0;
      tag_q <= '0;
    end else if (accept_o) begin
      gap_q <= (ivl_i != '0) ? ivl_i - 1'b1 : '0;
      tag_q <= tag_q + 1'b1;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end
endmodule

// File: rtl/fp_issue_ctrl.sv
`timescale 1ns/1ps
module fp_issue_ctrl #(
  parameter int DEPTH    = 3,
  parameter int LAT_W    = 6,
  parameter int TAG_W    = 2,
  parameter int IVL_W    = 2,
  parameter int LONG_MIN = 18,
  parameter int LONG_MAX = 33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic             dsp_valid_i,
  output logic             dsp_ready_o,
  input  logic [2:0]       dsp_cls_i,
  input  logic [LAT_W-1:0] dsp_lat_i,
  output logic [TAG_W-1:0] dsp_tag_o,
  output logic             cmp_valid_o,
  output logic [TAG_W-1:0] cmp_tag_o,
  output logic             cmp_fwd_o
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [LAT_W-1:0] lat_eff;
  logic [IVL_W-1:0] ivl;
  logic             blocking, fwd, accept, pop, head_fwd, blk_busy;
  logic [TAG_W-1:0] head_tag;
  logic [OCC_W-1:0] occ;

  fpi_class_decode #(.LAT_W(LAT_W), .IVL_W(IVL_W), .LONG_MIN(LONG_MIN),
                     .LONG_MAX(LONG_MAX)) u_dec (
    .cls_i(dsp_cls_i), .lat_req_i(dsp_lat_i), .lat_eff_o(lat_eff),
    .ivl_o(ivl), .blocking_o(blocking), .fwd_o(fwd));

  fpi_issue_gate #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IVL_W(IVL_W)) u_gate (
    .clk(clk), .rst(rst), .flush_i(flush_i), .valid_i(dsp_valid_i),
    .blocking_i(blocking), .ivl_i(ivl), .occ_i(occ), .blk_busy_i(blk_busy),
    .ready_o(dsp_ready_o), .accept_o(accept), .tag_o(dsp_tag_o));

  fpi_inflight_queue #(.DEPTH(DEPTH), .LAT_W(LAT_W), .TAG_W(TAG_W)) u_q (
    .clk(clk), .rst(rst), .flush_i(flush_i), .push_i(accept),
    .push_cnt_i(lat_eff - 1'b1), .push_tag_i(dsp_tag_o), .push_fwd_i(fwd),
    .push_blk_i(blocking), .pop_o(pop), .head_tag_o(head_tag),
    .head_fwd_o(head_fwd), .blk_busy_o(blk_busy), .occ_o(occ));

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      cmp_valid_o <= 1'b0;
      cmp_tag_o   <= '0;
      cmp_fwd_o   <= 1'b0;
    end else begin
      cmp_valid_o <= pop;
      cmp_tag_o   <= head_tag;
      cmp_fwd_o   <= pop && head_fwd;
    end
  end
endmodule

// File: rtl/fp_issue_ctrl_chk.sv
`timescale 1ns/1ps
module fp_issue_ctrl_chk #(
  parameter int DEPTH = 3,
  parameter int TAG_W = 2,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             flush_i,
  input logic             dsp_valid_i,
  input logic             dsp_ready_o,
  input logic [2:0]       dsp_cls_i,
  input logic             cmp_valid_o,
  input logic [TAG_W-1:0] cmp_tag_o,
  input logic             cmp_fwd_o,
  input logic [OCC_W-1:0] occ,
  input logic             blk_busy
);
  logic [TAG_W-1:0] exp_tag;
  logic             is_blk;

  assign is_blk = (dsp_cls_i == 3'd3) || (dsp_cls_i == 3'd4) || (dsp_cls_i == 3'd5);

  always_ff @(posedge clk) begin
    if (rst || flush_i)   exp_tag <= '0;
    else if (cmp_valid_o) exp_tag <= exp_tag + 1'b1;
  end

  // R1
  occ_limit_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= OCC_W'(DEPTH));
  // R1
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH)) |-> !dsp_ready_o);
  // R3
  slow_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid_i && dsp_ready_o && !flush_i && dsp_cls_i == 3'd1) |=> !dsp_ready_o);
  // R5
  blk_stall_chk: assert property (@(posedge clk) disable iff (rst)
    blk_busy |-> !dsp_ready_o);
  // R5
  blk_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (dsp_valid_i && dsp_ready_o && is_blk) |-> (occ == '0));
  // R6
  fwd_qual_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_fwd_o |-> cmp_valid_o);
  // R7
  tag_order_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_valid_o |-> (cmp_tag_o == exp_tag));
  // R8
  flush_clr_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (occ == '0 && !cmp_valid_o));
endmodule

bind fp_issue_ctrl fp_issue_ctrl_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .flush_i(flush_i), .dsp_valid_i(dsp_valid_i),
  .dsp_ready_o(dsp_ready_o), .dsp_cls_i(dsp_cls_i), .cmp_valid_o(cmp_valid_o),
  .cmp_tag_o(cmp_tag_o), .cmp_fwd_o(cmp_fwd_o), .occ(occ), .blk_busy(blk_busy));

// File: tb/sim_fp_issue_ctrl.sv
`timescale 1ns/1ps
module sim_fp_issue_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush_i = 1'b0;
  logic       dsp_valid_i = 1'b0;
  logic [2:0] dsp_cls_i = 3'd0;
  logic [5:0] dsp_lat_i = 6'd0;
  logic       dsp_ready_o, cmp_valid_o, cmp_fwd_o;
  logic [1:0] dsp_tag_o, cmp_tag_o;

  fp_issue_ctrl u0 (
    .clk(clk), .rst(rst), .flush_i(flush_i), .dsp_valid_i(dsp_valid_i),
    .dsp_ready_o(dsp_ready_o), .dsp_cls_i(dsp_cls_i), .dsp_lat_i(dsp_lat_i),
    .dsp_tag_o(dsp_tag_o), .cmp_valid_o(cmp_valid_o), .cmp_tag_o(cmp_tag_o),
    .cmp_fwd_o(cmp_fwd_o));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, n_done = 0, exp_tag = 0;
  int d_cyc [64];
  int d_tag [64];
  int d_fwd [64];
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && cmp_valid_o) begin
      d_cyc[n_done % 64] = cyc;
      d_tag[n_done % 64] = cmp_tag_o;
      d_fwd[n_done % 64] = cmp_fwd_o;
      n_done++;
    end
  end

  // {class, requested latency, expected latency, expected forward flag}
  localparam logic [15:0] VEC [12] = '{
    {3'd0, 6'd0,  6'd3,  1'b1}, {3'd1, 6'd0,  6'd4,  1'b1},
    {3'd2, 6'd0,  6'd4,  1'b1}, {3'd3, 6'd20, 6'd20, 1'b1},
    {3'd4, 6'd25, 6'd25, 1'b1}, {3'd3, 6'd5,  6'd18, 1'b1},
    {3'd4, 6'd63, 6'd33, 1'b1}, {3'd3, 6'd17, 6'd18, 1'b1},
    {3'd4, 6'd34, 6'd33, 1'b1}, {3'd5, 6'd0,  6'd3,  1'b1},
    {3'd6, 6'd0,  6'd3,  1'b0}, {3'd7, 6'd0,  6'd3,  1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [5:0] l,
                       output int acc, output int tg);
    int guard = 0;
    dsp_cls_i = c; dsp_lat_i = l; dsp_valid_i = 1'b1; #1;
    while (!dsp_ready_o && guard < 200) begin @(negedge clk); #1; guard++; end
    acc = cyc + 1;
    tg = dsp_tag_o;
    @(negedge clk);
    dsp_valid_i = 1'b0;
    exp_tag = (exp_tag + 1) % 4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int a0, a1, a2, t0, t1, n0, g;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk(dsp_ready_o == 1'b1, "R9 ready", dsp_ready_o, 1);
    chk(cmp_valid_o == 1'b0 && cmp_fwd_o == 1'b0, "R9 done", cmp_valid_o, 0);
    chk(dsp_tag_o == 2'd0, "R9 tag", dsp_tag_o, 0);
    @(negedge clk);

    // Table: each class from an empty pipeline (R2, R4, R6, R7)
    for (int k = 0; k < 12; k++) begin
      int et, el, ef, act;
      et = exp_tag;
      el = VEC[k][6:1];
      ef = VEC[k][0];
      n0 = n_done;
      issue(VEC[k][15:13], VEC[k][12:7], a0, t0);
      g = 0;
      while (n_done == n0 && g < 60) begin @(negedge clk); g++; end
      act = d_cyc[n0 % 64] - a0;
      chk(act == el, "R2/R4 latency", act, el);
      chk(d_fwd[n0 % 64] == ef, "R6 forward", d_fwd[n0 % 64], ef);
      chk(d_tag[n0 % 64] == et && t0 == et, "R7 tag", d_tag[n0 % 64], et);
      idle(2);
    end

    // R1 and R3: three fast ops back to back fill the pipeline
    n0 = n_done;
    issue(3'd0, 6'd0, a0, t0);
    issue(3'd0, 6'd0, a1, t1);
    issue(3'd0, 6'd0, a2, t1);
    chk(a1 - a0 == 1 && a2 - a1 == 1, "R3 interval one", a2 - a0, 2);
    dsp_cls_i = 3'd0; #1;
    chk(dsp_ready_o == 1'b0, "R1 full stall", dsp_ready_o, 0);
    idle(8);
    chk(n_done - n0 == 3, "R1 completions", n_done - n0, 3);
    chk(d_cyc[(n0 + 2) % 64] - a0 == 5, "R7 fill order", d_cyc[(n0 + 2) % 64] - a0, 5);

    // R3: slow op leaves a two-cycle gap
    issue(3'd1, 6'd0, a0, t0);
    issue(3'd0, 6'd0, a1, t1);
    chk(a1 - a0 == 2, "R3 interval two", a1 - a0, 2);
    idle(8);

    // R7: medium then fast, the fast one waits one cycle
    n0 = n_done;
    issue(3'd2, 6'd0, a0, t0);
    issue(3'd0, 6'd0, a1, t1);
    idle(8);
    chk(d_cyc[(n0 + 1) % 64] - a0 == 5, "R7 in order", d_cyc[(n0 + 1) % 64] - a0, 5);
    chk(d_tag[(n0 + 1) % 64] == t1, "R7 second tag", d_tag[(n0 + 1) % 64], t1);

    // R5: divide waits for empty pipe, then blocks a later op
    issue(3'd0, 6'd0, a0, t0);
    issue(3'd3, 6'd20, a1, t1);
    chk(a1 - a0 == 4, "R5 waits for empty", a1 - a0, 4);
    issue(3'd0, 6'd0, a2, t0);
    chk(a2 - a1 == 21, "R5 blocks follower", a2 - a1, 21);
    idle(8);

    // R5: status/control move blocks too
    issue(3'd5, 6'd0, a0, t0);
    issue(3'd2, 6'd0, a1, t1);
    chk(a1 - a0 == 4, "R5 control move", a1 - a0, 4);
    idle(8);

    // R8: flush during a long divide
    issue(3'd3, 6'd30, a0, t0);
    idle(4);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    exp_tag = 0;
    dsp_cls_i = 3'd0; #1;
    chk(dsp_ready_o == 1'b1, "R8 ready", dsp_ready_o, 1);
    chk(dsp_tag_o == 2'd0, "R8 tag reset", dsp_tag_o, 0);
    n0 = n_done;
    idle(40);
    chk(n_done == n0, "R8 no completion", n_done - n0, 0);

    finish_run();
  end
endmodule